// File: doc/BRIEF.md
# Configurable Tree Routing Multiplexer

This block picks one signal out of a set of routed wires in a programmable fabric and drives it onto a single output. Beside the N routed inputs the candidate set holds one extra leaf tied to logic 1. The leaves are padded with further constant-1 leaves up to the next power of two. They then feed a binary tree of 2:1 select cells. Each tree level is steered by one bit of a static configuration vector. The block itself does not store or load these bits; they arrive on a plain input port from the fabric's configuration storage.

Every leaf passes through an inverting input buffer and the tree result leaves through an inverting output buffer, so the path as a whole does not invert. Each select cell forwards its first (even-index) input when its select bit is 1. The cell at the root is a separate cell module from the inner cells, so that a different library cell can be put there, but both cells compute the same function. The block is purely combinational and has no clock or reset.

Top module: `rmux_tree`

## Requirements
- R1: For a configuration code c, the routed leaf index is the bitwise complement of c over CFG_W bits. When that index is below N_IN, out_o equals data_i at that index.
- R2: When the complemented code equals N_IN, the constant leaf is routed and out_o is 1 whatever data_i holds.
- R3: Leaves with an index above N_IN, which exist whenever N_IN+1 is not a power of two, are tied to 1. Selecting one drives out_o to 1.
- R4: A select cell whose select bit is 1 forwards its first, even-index input. Code all-ones therefore routes data_i[0].
- R5: cfg_i is ceil(log2(N_IN+1)) bits wide. Bit b steers tree level b, with bit 0 at the level next to the leaves. Toggling bit b toggles bit b of the routed index.
- R6: The output polarity matches the routed input for both 0 and 1, because the input and output inversions cancel.
- R7: Every code value gives a known output that follows data_i and cfg_i combinationally, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N_IN | Routed candidate signals, index 0 first |
| cfg_i | input | CFG_W | Static per-level select bits, bit 0 at the leaf level |
| out_o | output | 1 | Routed signal |

## Verification
Assertions placed in the top module check on every evaluation the following properties. The output must match the leaf picked by the complemented code (R1). It must be 1 whenever the constant or a padding leaf is picked (R2, R3). It must be the inverse of the tree root (R6), and it must never be unknown while the code is known (R7). Only the bench scenarios can show the cell convention and level ordering (R4, R5) as separate facts, by flipping single code bits and seeing which neighbour input is routed. They also sweep every code against walking-one and walking-zero data on two input counts, one of which has padding leaves beyond the constant.

// File: rtl/rmux_pkg.sv
`timescale 1ns/1ps
package rmux_pkg;
  // value of the extra leaf and of every padding leaf
  localparam logic CONST_LEAF = 1'b1;

  // tree depth for n routed inputs plus the constant leaf
  function automatic int rmux_levels(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rmux_inv.sv
`timescale 1ns/1ps
module rmux_inv #(
  parameter int W = 1
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  assign y_o = ~a_i;
endmodule

// File: rtl/rmux_mid_cell.sv
`timescale 1ns/1ps
// inner tree stage select cell: select high forwards the first input
module rmux_mid_cell (
  input  logic first_i,
  input  logic second_i,
  input  logic sel_i,
  output logic y_o
);
  assign y_o = sel_i ? first_i : second_i;
endmodule

// File: rtl/rmux_last_cell.sv
`timescale 1ns/1ps
// root stage select cell, kept apart so a distinct cell can be mapped here
module rmux_last_cell (
  input  logic first_i,
  input  logic second_i,
  input  logic sel_i,
  output logic y_o
);
  always_comb begin
    if (sel_i) y_o = first_i;
    else       y_o = second_i;
  end
endmodule

// File: rtl/rmux_tree.sv
`timescale 1ns/1ps
module rmux_tree
  import rmux_pkg::*;
#(
  parameter  int N_IN  = 6,
  localparam int CFG_W = rmux_levels(N_IN)
) (
  input  logic [N_IN-1:0]  data_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             out_o
);
  localparam int PADDED = 1 << CFG_W;
  localparam int PAD_W  = PADDED - N_IN;

  logic [PADDED-1:0]     leaf_raw;
  logic [PADDED-1:0]     leaf_n;
  // heap-ordered tree: node 1 is the root, leaves sit at PADDED..2*PADDED-1
  logic [2*PADDED-1:1]   tnode;

  assign leaf_raw = {{PAD_W{CONST_LEAF}}, data_i};

  rmux_inv #(.W(PADDED)) u_in_inv (
    .a_i (leaf_raw),
    .y_o (leaf_n)
  );

  assign tnode[2*PADDED-1:PADDED] = leaf_n;

  // depth d from the root uses cfg bit CFG_W-1-d
  for (genvar d = 0; d < CFG_W; d++) begin : g_depth
    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int NODE = (1 << d) + j;
      if (d == 0) begin : g_root
        rmux_last_cell u_cell (
          .first_i  (tnode[2*NODE]),
          .second_i (tnode[2*NODE+1]),
          .sel_i    (cfg_i[CFG_W-1-d]),
          .y_o      (tnode[NODE])
        );
      end else begin : g_inner
        rmux_mid_cell u_cell (
          .first_i  (tnode[2*NODE]),
          .second_i (tnode[2*NODE+1]),
          .sel_i    (cfg_i[CFG_W-1-d]),
          .y_o      (tnode[NODE])
        );
      end
    end
  end

  rmux_inv #(.W(1)) u_out_inv (
    .a_i (tnode[1]),
    .y_o (out_o)
  );

  // ---------------- assertions ----------------
  logic [CFG_W-1:0] chk_idx;
  logic             chk_in_range;
  logic             chk_exp;

  always_comb begin
    chk_idx      = ~cfg_i;
    chk_in_range = 1'b0;
    chk_exp      = CONST_LEAF;
    for (int k = 0; k < N_IN; k++) begin
      if (CFG_W'(k) == chk_idx) begin
        chk_in_range = 1'b1;
        chk_exp      = data_i[k];
      end
    end
  end

  always_comb begin
    if (!$isunknown({cfg_i, data_i})) begin
      p_route_r1: assert (!chk_in_range || out_o == chk_exp)
        else $error("routed input mismatch");
      // covers both the constant leaf (R2) and padding leaves (R3)
      p_const_r2: assert (chk_in_range || out_o == 1'b1)
        else $error("constant leaf not 1");
      p_polarity_r6: assert (out_o == ~tnode[1])
        else $error("output not inverse of tree root");
    end
    if (!$isunknown(cfg_i)) begin
      p_no_x_r7: assert (!$isunknown(out_o) || $isunknown(data_i))
        else $error("unknown output");
    end
  end
endmodule

// File: tb/rmux_tree_tb.sv
`timescale 1ns/1ps
module rmux_tree_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [5:0] data6;
  logic [2:0] cfg6;
  logic       out6;
  logic [1:0] data2;
  logic [1:0] cfg2;
  logic       out2;

  rmux_tree #(.N_IN(6)) dut_i (
    .data_i (data6),
    .cfg_i  (cfg6),
    .out_o  (out6)
  );

  rmux_tree #(.N_IN(2)) dut_small_i (
    .data_i (data2),
    .cfg_i  (cfg2),
    .out_o  (out2)
  );

  // {cfg, data, expected}
  localparam logic [9:0] VEC [10] = '{
    {3'd7, 6'b000001, 1'b1},
    {3'd7, 6'b111110, 1'b0},
    {3'd6, 6'b000010, 1'b1},
    {3'd6, 6'b111101, 1'b0},
    {3'd5, 6'b000100, 1'b1},
    {3'd4, 6'b110111, 1'b0},
    {3'd3, 6'b010000, 1'b1},
    {3'd2, 6'b011111, 1'b0},
    {3'd1, 6'b000000, 1'b1},
    {3'd0, 6'b000000, 1'b1}
  };

  function automatic logic model6(input logic [2:0] c, input logic [5:0] d);
    int idx = 7 - int'(c);
    if (idx < 6) return d[idx];
    return 1'b1;
  endfunction

  function automatic logic model2(input logic [1:0] c, input logic [1:0] d);
    int idx = 3 - int'(c);
    if (idx < 2) return d[idx];
    return 1'b1;
  endfunction

  function automatic string tag6(input logic [2:0] c);
    int idx = 7 - int'(c);
    if (idx < 6) return "R1";
    if (idx == 6) return "R2";
    return "R3";
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic apply6(input logic [2:0] c, input logic [5:0] d);
    @(negedge clk);
    cfg6  = c;
    data6 = d;
    #1;
  endtask

  initial begin
    data6 = '0; cfg6 = '0; data2 = '0; cfg2 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // start-up state: code 0 routes a padding leaf on both instances
    check(out6, 1'b1, "R3", "startup padding leaf N=6");
    check(out2, 1'b1, "R3", "startup padding leaf N=2");

    // table walk; zero results also show R6 polarity
    for (int v = 0; v < 10; v++) begin
      apply6(VEC[v][9:7], VEC[v][6:1]);
      check(out6, VEC[v][0], tag6(VEC[v][9:7]), $sformatf("vector %0d", v));
      if (VEC[v][0] == 1'b0) check(out6, 1'b0, "R6", $sformatf("low polarity vector %0d", v));
    end

    // R2: constant wins over all-zero and all-one data
    apply6(3'd1, 6'b111111);
    check(out6, 1'b1, "R2", "constant with data ones");

    // R4: all-ones code routes input 0 (first input at every level)
    apply6(3'b111, 6'b000001);
    check(out6, 1'b1, "R4", "all-ones code picks input 0");
    apply6(3'b111, 6'b111110);
    check(out6, 1'b0, "R4", "all-ones code picks input 0 low");

    // R5: bit 0 toggles between neighbours, bit 2 jumps by four
    apply6(3'b101, 6'b000100);
    check(out6, 1'b1, "R5", "code 5 routes input 2");
    apply6(3'b100, 6'b000100);
    check(out6, 1'b0, "R5", "bit0 flip routes input 3");
    apply6(3'b011, 6'b010000);
    check(out6, 1'b1, "R5", "code 3 routes input 4");
    apply6(3'b111, 6'b010000);
    check(out6, 1'b0, "R5", "bit2 flip routes input 0");

    // R7: exhaustive code sweep, walking one and walking zero
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 12; p++) begin
        logic [5:0] d;
        d = (p < 6) ? (6'b1 << p) : ~(6'b1 << (p - 6));
        apply6(3'(c), d);
        check($isunknown(out6), 1'b0, "R7", "known output");
        check(out6, model6(3'(c), d), "R7", $sformatf("sweep code %0d data %b", c, d));
      end
    end

    // R7: data change alone, no clock edge in between
    @(negedge clk);
    cfg6 = 3'd6; data6 = 6'b000000; #0.5;
    check(out6, 1'b0, "R7", "combinational low");
    data6 = 6'b000010; #0.5;
    check(out6, 1'b1, "R7", "combinational high");

    // small instance: constant at index 2, padding at index 3
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 4; d++) begin
        @(negedge clk);
        cfg2 = 2'(c); data2 = 2'(d);
        #1;
        check(out2, model2(2'(c), 2'(d)),
              (c == 0) ? "R3" : (c == 1) ? "R2" : "R1",
              $sformatf("N=2 code %0d data %0d", c, d));
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule